// File: doc/BRIEF.md
# I2C Controller Interrupt Register Bank

This block holds the interrupt state of an I2C controller. Twelve event sources feed it. Ten of them are single-cycle pulses, and each one sets a sticky raw status bit. The other two follow FIFO level conditions directly. A mask register selects which raw bits reach the masked status view and the single interrupt line.

Software clears a sticky bit by reading a dedicated clear address for that source. A read of the combined clear address drops every sticky bit at once. A separate abort-cause register collects the reasons behind a transmit abort. It empties together with the abort bit, so software must read it before it reads the abort clear.

The protocol engine that produces the event pulses and the abort causes is outside this block. The bench drives them from a stub.

Top module: `i2c_irq_bank`

## Requirements
- R1: Bit positions in raw status are: 0 receive underflow, 1 receive overflow, 2 receive level reached, 3 transmit overflow, 4 transmit level low, 5 read request, 6 transmit abort, 7 receive done, 8 activity, 9 stop seen, 10 start seen, 11 general call. A one on `ev_pulse[i]` for a sticky bit i (all bits except 2 and 4) sets raw bit i at the next clock edge. The bit then stays set until it is cleared.
- R2: A read at address 0 returns the raw status. A read at address 1 returns the raw status ANDed with the mask register.
- R3: `irq_o` is high exactly when at least one masked status bit is set.
- R4: A read at address 16+i (i from 0 to 11) returns raw bit i in `rd_data[0]`, with the upper bits zero. It clears sticky bit i and no other bit.
- R5: A read at address 4 returns the raw status as it was before the read. It clears every sticky bit and the abort-cause register.
- R6: If an event pulse for a bit arrives in the same cycle as a read that clears that bit, the bit stays set.
- R7: The abort-cause register is read at address 3 and is 13 bits wide. Each high bit of `abrt_cause` is ORed into it. Its positions are: 0 7-bit address not acknowledged, 1 first 10-bit address byte not acknowledged, 2 second 10-bit address byte not acknowledged, 3 data not acknowledged, 4 general call not acknowledged, 5 read after general call, 7 start byte acknowledged, 9 start byte with restart off, 10 10-bit read with restart off, 11 controller disabled, 12 arbitration lost. It is cleared by a read of address 22 (the abort clear) or of address 4. Cause bits that arrive in the same cycle as such a read are kept.
- R8: Raw bit 2 equals `rx_at_level` and raw bit 4 equals `tx_at_level` in the same cycle. `ev_pulse[2]`, `ev_pulse[4]` and reads of addresses 18 and 20 have no effect on these bits.
- R9: After reset, all state is zero: raw status, mask and abort cause. A write at address 2 loads `wr_data` into the mask. Writes to any other address are ignored.
- R10: `rd_data` is registered. It shows the read value in the cycle after `rd_en` and is zero after a cycle without a read. Reads of unmapped addresses return zero and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_pulse | input | 12 | One-cycle event pulses, one per status bit |
| rx_at_level | input | 1 | Receive FIFO at or above its threshold |
| tx_at_level | input | 1 | Transmit FIFO at or below its threshold |
| abrt_cause | input | 13 | Transmit abort cause pulses |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 6 | Register read address |
| rd_data | output | 16 | Registered read data |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 12 | Register write data |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that `rst_n` is asserted at start-up. They assume that every input is stable across a clock edge. They make no assumption about how events and reads are timed relative to each other. The stimulus changes inputs only on the falling clock edge. It deliberately lets event pulses and cause pulses fall in the same cycle as reads of the clear addresses, so the set-wins rule is exercised. Read addresses are drawn from the mapped registers, the clear range and the unmapped space alike, so the unmapped reads and the reads of the level-bit clears that must do nothing are hit often.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int NSRC    = 12;
  localparam int CAUSE_W = 13;
  localparam int AW      = 6;
  localparam int DW      = 16;

  localparam int B_RX_LVL = 2;
  localparam int B_TX_LVL = 4;
  localparam int B_ABORT  = 6;

  localparam logic [NSRC-1:0] LEVEL_MASK = NSRC'((1 << B_RX_LVL) | (1 << B_TX_LVL));

  localparam logic [AW-1:0] A_RAW      = AW'(0);
  localparam logic [AW-1:0] A_MASKED   = AW'(1);
  localparam logic [AW-1:0] A_MASK     = AW'(2);
  localparam logic [AW-1:0] A_CAUSE    = AW'(3);
  localparam logic [AW-1:0] A_CLR_ALL  = AW'(4);
  localparam logic [AW-1:0] A_CLR_BASE = AW'(16);

  // next value of a sticky bit vector: set wins over clear
  function automatic logic [NSRC-1:0] sticky_next(logic [NSRC-1:0] cur,
                                                  logic [NSRC-1:0] set,
                                                  logic [NSRC-1:0] clr);
    return set | (cur & ~clr);
  endfunction

  // address of the per-source clear register
  function automatic logic [AW-1:0] clr_addr(int idx);
    return A_CLR_BASE + AW'(idx);
  endfunction
endpackage

// File: rtl/irq_status_bits.sv
module irq_status_bits
  import i2c_irq_pkg::*;
#(
  parameter int              N     = NSRC,
  parameter logic [N-1:0]    LVL_M = LEVEL_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_pulse,
  input  logic [N-1:0] lvl_in,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] raw
);
  logic [N-1:0] sticky_q;
  logic [N-1:0] sticky_d;

  assign sticky_d = sticky_next(sticky_q, ev_pulse & ~LVL_M, clr_vec & ~LVL_M);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sticky_q[i] <= 1'b0;
      else        sticky_q[i] <= sticky_d[i];
    end
    assign raw[i] = LVL_M[i] ? lvl_in[i] : sticky_q[i];

    if (!LVL_M[i]) begin : g_chk
      p_event_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pulse[i] |=> raw[i]);
      p_sticky_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (raw[i] && !clr_vec[i]) |=> raw[i]);
      p_clear_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec[i] && !ev_pulse[i]) |=> !raw[i]);
      p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec[i] && ev_pulse[i]) |=> raw[i]);
    end
  end
endmodule

// File: rtl/irq_abort_cause.sv
module irq_abort_cause
  import i2c_irq_pkg::*;
#(
  parameter int W = CAUSE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cause_in,
  input  logic         cause_clr,
  output logic [W-1:0] cause_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_in | (cause_q & ~{W{cause_clr}});
  end

  p_cause_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_clr && cause_in == '0) |=> cause_q == '0);
  p_cause_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|cause_in) |=> ((cause_q & $past(cause_in)) == $past(cause_in)));
endmodule

// File: rtl/irq_reg_access.sv
module irq_reg_access
  import i2c_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC-1:0]    raw,
  input  logic [CAUSE_W-1:0] cause,
  input  logic               rd_en,
  input  logic [AW-1:0]      rd_addr,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [NSRC-1:0]    wr_data,
  output logic [NSRC-1:0]    masked,
  output logic [NSRC-1:0]    clr_vec,
  output logic               cause_clr,
  output logic [DW-1:0]      rd_data
);
  logic [NSRC-1:0] mask_q;
  logic [DW-1:0]   rd_val;

  assign masked = raw & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          mask_q <= '0;
    else if (wr_en && wr_addr == A_MASK) mask_q <= wr_data;
  end

  always_comb begin
    clr_vec = '0;
    if (rd_en) begin
      if (rd_addr == A_CLR_ALL) clr_vec = '1;
      for (int i = 0; i < NSRC; i++)
        if (rd_addr == clr_addr(i)) clr_vec[i] = 1'b1;
    end
  end
  assign cause_clr = clr_vec[B_ABORT];

  always_comb begin
    rd_val = '0;
    unique case (rd_addr)
      A_RAW:     rd_val = DW'(raw);
      A_MASKED:  rd_val = DW'(masked);
      A_MASK:    rd_val = DW'(mask_q);
      A_CAUSE:   rd_val = DW'(cause);
      A_CLR_ALL: rd_val = DW'(raw);
      default: begin
        for (int i = 0; i < NSRC; i++)
          if (rd_addr == clr_addr(i)) rd_val = DW'(raw[i]);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_en ? rd_val : '0;
  end

  p_mask_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_MASK) |=> mask_q == $past(wr_data));
  p_mask_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == A_MASK) |=> $stable(mask_q));
  p_idle_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rd_data == '0);
endmodule

// File: rtl/i2c_irq_bank.sv
module i2c_irq_bank
  import i2c_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC-1:0]    ev_pulse,
  input  logic               rx_at_level,
  input  logic               tx_at_level,
  input  logic [CAUSE_W-1:0] abrt_cause,
  input  logic               rd_en,
  input  logic [AW-1:0]      rd_addr,
  output logic [DW-1:0]      rd_data,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [NSRC-1:0]    wr_data,
  output logic               irq_o
);
  logic [NSRC-1:0]    lvl_vec;
  logic [NSRC-1:0]    raw_w;
  logic [NSRC-1:0]    masked_w;
  logic [NSRC-1:0]    clr_w;
  logic               cause_clr_w;
  logic [CAUSE_W-1:0] cause_w;

  always_comb begin
    lvl_vec           = '0;
    lvl_vec[B_RX_LVL] = rx_at_level;
    lvl_vec[B_TX_LVL] = tx_at_level;
  end

  irq_status_bits #(.N(NSRC), .LVL_M(LEVEL_MASK)) i_status (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .lvl_in(lvl_vec),
    .clr_vec(clr_w), .raw(raw_w)
  );

  irq_abort_cause #(.W(CAUSE_W)) i_cause (
    .clk(clk), .rst_n(rst_n), .cause_in(abrt_cause), .cause_clr(cause_clr_w),
    .cause_q(cause_w)
  );

  irq_reg_access i_regs (
    .clk(clk), .rst_n(rst_n), .raw(raw_w), .cause(cause_w),
    .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .masked(masked_w), .clr_vec(clr_w),
    .cause_clr(cause_clr_w), .rd_data(rd_data)
  );

  assign irq_o = |masked_w;

  p_irq_has_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (raw_w != '0));
  p_level_clear_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_w & ~LEVEL_MASK) || (rd_en && rd_addr == A_CLR_ALL));
endmodule

// File: tb/test_i2c_irq_bank.sv
module test_i2c_irq_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] ev_pulse;
  logic        rx_at_level, tx_at_level;
  logic [12:0] abrt_cause;
  logic        rd_en, wr_en;
  logic [5:0]  rd_addr, wr_addr;
  logic [11:0] wr_data;
  logic [15:0] rd_data;
  logic        irq_o;

  always #4 clk = ~clk;

  i2c_irq_bank i_i2c_irq_bank (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .rx_at_level(rx_at_level),
    .tx_at_level(tx_at_level), .abrt_cause(abrt_cause), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq_o(irq_o)
  );

  localparam logic [11:0] LVLS = 12'h014;
  int          n_tests = 0;
  int          n_fail  = 0;
  logic [11:0] m_raw   = '0;
  logic [11:0] m_mask  = '0;
  logic [12:0] m_cause = '0;
  logic        lr = 1'b0, lt = 1'b0;

  function automatic logic [15:0] exp_read(logic [5:0] a, logic [11:0] view,
                                           logic [11:0] msk, logic [12:0] cs);
    if (a == 6'd0 || a == 6'd4) return {4'h0, view};
    if (a == 6'd1) return {4'h0, view & msk};
    if (a == 6'd2) return {4'h0, msk};
    if (a == 6'd3) return {3'h0, cs};
    if (a >= 6'd16 && a < 6'd28) return {15'h0, view[a - 6'd16]};
    return 16'h0;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic [11:0] ev, logic [12:0] cs, logic rd, logic [5:0] ra,
                     logic wr, logic [5:0] wa, logic [11:0] wd, string tag);
    logic [11:0] lv, clr;
    logic [15:0] er;
    logic        cclr;
    @(negedge clk);
    ev_pulse = ev; abrt_cause = cs; rd_en = rd; rd_addr = ra;
    wr_en = wr; wr_addr = wa; wr_data = wd; rx_at_level = lr; tx_at_level = lt;
    lv = {7'h0, lt, 1'b0, lr, 2'b00};
    er = exp_read(ra, m_raw | lv, m_mask, m_cause);
    clr = '0;
    if (rd && ra == 6'd4) clr = ~LVLS;
    else if (rd && ra >= 6'd16 && ra < 6'd28) clr = (12'd1 << (ra - 6'd16)) & ~LVLS;
    cclr = rd && (ra == 6'd4 || ra == 6'd22);
    m_raw   = (ev & ~LVLS) | (m_raw & ~clr);
    m_cause = cs | (m_cause & ~{13{cclr}});
    if (wr && wa == 6'd2) m_mask = wd;
    @(posedge clk); #1;
    check({tag, " rd_data"}, rd_data, rd ? er : 16'h0);
    check({tag, " irq"}, {15'h0, irq_o}, {15'h0, |((m_raw | lv) & m_mask)});
  endtask

  task automatic rdc(logic [5:0] a, string tag);
    cyc('0, '0, 1'b1, a, 1'b0, '0, '0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [5:0] ra;
    rst_n = 1'b0; ev_pulse = '0; abrt_cause = '0; rd_en = 0; rd_addr = '0;
    wr_en = 0; wr_addr = '0; wr_data = '0; rx_at_level = 0; tx_at_level = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R9 reset irq", {15'h0, irq_o}, 16'h0);
    check("R10 reset rd_data", rd_data, 16'h0);
    rdc(6'd0, "R9 reset raw");
    rdc(6'd2, "R9 reset mask");
    rdc(6'd3, "R9 reset cause");
    // R1 all pulse bits, R8 pulses on level bits ignored
    cyc(12'hFFF, '0, 1'b0, '0, 1'b0, '0, '0, "R1 pulse all");
    rdc(6'd0, "R1 R8 raw after pulses");
    cyc('0, '0, 1'b0, '0, 1'b1, 6'd3, 12'hFFF, "R9 write wrong addr");
    rdc(6'd2, "R9 mask unchanged");
    cyc('0, '0, 1'b0, '0, 1'b1, 6'd2, 12'h041, "R2 R3 mask write");
    rdc(6'd1, "R2 masked view");
    rdc(6'd16, "R4 clear bit0");
    rdc(6'd0, "R4 others kept");
    rdc(6'd16, "R4 bit0 reads zero");
    cyc(12'h002, '0, 1'b1, 6'd17, 1'b0, '0, '0, "R6 set with clear");
    rdc(6'd0, "R6 bit1 kept");
    rdc(6'd22, "R7 clear abort");
    rdc(6'd1, "R3 masked after clear");
    cyc('0, 13'h1009, 1'b0, '0, 1'b0, '0, '0, "R7 cause in");
    cyc(12'h040, 13'h0080, 1'b0, '0, 1'b0, '0, '0, "R7 cause accumulate");
    rdc(6'd3, "R7 cause read");
    cyc('0, 13'h0004, 1'b1, 6'd22, 1'b0, '0, '0, "R7 cause set wins");
    rdc(6'd3, "R7 cause after clear");
    rdc(6'd22, "R7 cause cleared");
    rdc(6'd3, "R7 cause empty");
    lr = 1'b1;
    rdc(6'd0, "R8 rx level shown");
    rdc(6'd18, "R8 level clear read");
    rdc(6'd0, "R8 level unaffected");
    lt = 1'b1; lr = 1'b0;
    cyc('0, '0, 1'b0, '0, 1'b1, 6'd2, 12'h010, "R8 R3 level irq");
    rdc(6'd20, "R8 tx clear read");
    lt = 1'b0;
    rdc(6'd0, "R8 level follows");
    cyc(12'hAA9, 13'h1FFF, 1'b0, '0, 1'b0, '0, '0, "R5 load");
    rdc(6'd4, "R5 combined clear");
    rdc(6'd0, "R5 raw empty");
    rdc(6'd3, "R5 cause empty");
    rdc(6'd5, "R10 unmapped 5");
    rdc(6'd28, "R10 unmapped 28");
    rdc(6'd63, "R10 unmapped 63");
    void'($urandom(32'd4711));
    for (int k = 0; k < 4000; k++) begin
      int sel;
      sel = $urandom % 8;
      if (sel < 5)       ra = 6'(sel);
      else if (sel < 7)  ra = 6'd16 + 6'($urandom % 12);
      else               ra = 6'($urandom);
      if ($urandom % 6 == 0) lr = ~lr;
      if ($urandom % 6 == 0) lt = ~lt;
      cyc(12'($urandom & $urandom & $urandom), 13'($urandom & $urandom & $urandom),
          1'($urandom), ra, ($urandom % 8) == 0, 6'd2, 12'($urandom),
          "R1 R2 R4 R6 R7 random");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule